// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block is the host-side master for an 8-bit, multi-channel successive-approximation converter reached over a four-wire serial link: an active-low chip select, a serial clock, a host-to-converter data line and a converter-to-host data line. A client asks for a channel with a request/ready handshake. The controller shifts the 4-bit channel address out and waits for the conversion to finish. It then clocks the 8-bit result back in and presents it with a one-cycle valid strobe. Addresses whose two upper bits are both set would put the converter into a factory test mode, so they are refused and flagged instead of being sent.

The serial clock comes from a clock-enable divider on the system clock. The controller drives the host data line only while the serial clock is low and samples the converter's output just as the serial clock rises. Every frame has 8 serial clocks of address, a pause, and 8 serial clocks of result. The pause starts with a programmable settle delay that lets the converter finish sampling. Conversion completion is found in one of two ways, chosen per request:
- In watch mode, chip select stays low and the controller waits for the converter's busy-low level on its output line to end. A timeout counted in conversion-clock periods guards against a line that never rises.
- In release mode, chip select is raised during the conversion and the full worst-case conversion time is counted before chip select is lowered for the read.

A read consumes the sample. Every request therefore always sends a fresh address frame.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After acceptance, the address frame is 8 SCLK periods. `di` carries the channel address bit 3 first, down to bit 0, and is then 0 for the last four periods. `di` changes only while SCLK is low and is stable while SCLK is high.
- R2: A request whose channel has bits [3:2] = 2'b11 (12 to 15) is refused. `err_addr` is high for exactly the next cycle, `cs_n` stays high, SCLK stays low and `busy` stays low. Channels 0 to 11 are accepted.
- R3: `req_ready` is high only when the controller is idle. `busy` is high from the cycle after acceptance until the cycle in which `res_valid` or `err_timeout` is high. In that cycle `busy` is low.
- R4: SCLK idles low and has a period of 2*SCLK_HALF system clocks. SCLK is low whenever `cs_n` is high, and after reset.
- R5: After the 8th falling edge of the address frame, SCLK stays low for at least SETTLE_CYC system clocks.
- R6: In watch mode (`req_release`=0 at acceptance), `cs_n` stays low for the whole transaction. The read begins once `do_in` is seen high.
- R7: In release mode (`req_release`=1), `cs_n` rises at the 8th falling edge of the address frame. It falls again no sooner than CONV_MAX*CONV_DIV system clocks later, and the read then follows.
- R8: The result is 8 bits, MSB first, each sampled from `do_in` as SCLK rises. `res_data` holds it while `res_valid` is high for exactly one cycle.
- R9: In watch mode, if `do_in` stays low for CONV_MAX+CONV_MARGIN conversion-clock periods (CONV_DIV system clocks each) after the address frame, `err_timeout` pulses for one cycle. `cs_n` is then high, no result is delivered and the controller is idle.
- R10: Each transaction has exactly 16 SCLK rising edges (8 address, 8 result) and ends with `cs_n` high. A later request always starts a new address frame and returns a new conversion, never the consumed sample.
- R11: A request presented in the cycle in which `res_valid` is high is accepted at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Conversion request |
| req_chan | input | 4 | Requested channel number |
| req_release | input | 1 | 1: release chip select during conversion; 0: watch the data line |
| req_ready | output | 1 | Controller idle, request can be taken |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle strobe, result available |
| res_data | output | 8 | Conversion result |
| err_addr | output | 1 | One-cycle strobe, test-mode address refused |
| err_timeout | output | 1 | One-cycle strobe, end of conversion not seen in time |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to converter |
| di | output | 1 | Serial data to converter |
| do_in | input | 1 | Serial data from converter |

## Verification
The delivery of a result and the acceptance of the next request can fall in the same clock edge. The controller returns to idle at the edge that raises `res_valid`, so `req_ready` is already high while the strobe is up. The bench holds `req_valid` high across a whole transaction and changes the converter model's sample in the middle of it. It then judges that the first result is correct, that `req_ready` is high in the strobe cycle, that `busy` and a low `cs_n` follow in the next cycle, and that the second result is the new sample rather than the consumed one.

// File: rtl/sadc_pkg.sv
// Shared constants and types for the serial ADC host controller.
// Assumes a converter with a 4-bit address and an 8-bit result.
package sadc_pkg;

    localparam int SADC_ADDR_W      = 4;
    localparam int SADC_DATA_W      = 8;
    localparam int SADC_FRAME_CLKS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEND   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_READ   = 3'd4
    } sadc_state_t;

endpackage

// File: rtl/sadc_sclk_gen.sv
// Serial clock generator. While run is high, sclk toggles every HALF
// system clocks, starting low. rise_tick / fall_tick are high in the cycle
// whose closing edge makes sclk rise / fall. With run low, sclk is held low
// and the phase counter is cleared. Assumes HALF >= 1.
module sadc_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] phase;
    logic          wrap;

    assign wrap      = run && (phase == LAST);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    // Phase counter and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            phase <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            phase <= '0;
            sclk  <= !sclk;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_conv_timer.sv
// Conversion-clock timer. While run is high, a prescaler divides the system
// clock by DIV and count advances once per conversion-clock period. count
// saturates at SAT. Dropping run clears both counters.
module sadc_conv_timer #(
    parameter int DIV = 4,
    parameter int CW  = 7,
    parameter int SAT = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] count
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(SAT);

    logic [PW-1:0] pre;
    logic          tick;

    assign tick = run && (pre == PRE_LAST);

    // Prescaler and saturating period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre   <= '0;
            count <= '0;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick && (count != CNT_SAT)) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sadc_shifter.sv
// Shared shift register. A parallel load sets it. shift_en moves it one
// place towards the MSB and fills the LSB with shift_in. The MSB drives the
// outgoing serial line, and after W shifts the register holds the W
// incoming bits, first bit in the MSB.
module sadc_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] q
);

    // Load or shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[W-2:0], shift_in};
        end
    end

endmodule

// File: rtl/sadc_host_ctrl.sv
// Host-side controller for a serial 8-bit converter.
// - Takes a channel through a request/ready handshake and refuses
//   test-mode addresses (bits [3:2] both set).
// - Sends an 8-clock address frame, MSB first, followed by zero padding.
// - Holds the serial clock low for a settle delay, then waits for end of
//   conversion in one of two ways. In watch mode chip select stays low and
//   the controller waits for the data line to rise, with a timeout. In
//   release mode chip select is raised and the worst-case time is counted.
// - Reads 8 result bits, MSB first, on rising serial clock edges.
// Assumes do_in changes only on serial clock edges this block produces,
// which are registered in the clk domain.
module sadc_host_ctrl
    import sadc_pkg::*;
#(
    parameter int SCLK_HALF   = 2,
    parameter int SETTLE_CYC  = 20,
    parameter int CONV_DIV    = 4,
    parameter int CONV_MAX    = 64,
    parameter int CONV_MARGIN = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [SADC_ADDR_W-1:0] req_chan,
    input  logic                   req_release,
    output logic                   req_ready,
    output logic                   busy,
    output logic                   res_valid,
    output logic [SADC_DATA_W-1:0] res_data,
    output logic                   err_addr,
    output logic                   err_timeout,
    output logic                   cs_n,
    output logic                   sclk,
    output logic                   di,
    input  logic                   do_in
);

    localparam int FC_W = $clog2(SADC_FRAME_CLKS);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(SADC_FRAME_CLKS - 1);
    localparam int SC_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);
    localparam int CT_W = $clog2(CONV_MAX + CONV_MARGIN + 1);
    localparam logic [CT_W-1:0] CONV_DONE  = CT_W'(CONV_MAX);
    localparam logic [CT_W-1:0] CONV_LIMIT = CT_W'(CONV_MAX + CONV_MARGIN);
    localparam int PAD_W = SADC_DATA_W - SADC_ADDR_W;

    sadc_state_t            state;
    logic [FC_W-1:0]        edge_cnt;
    logic [SC_W-1:0]        settle_cnt;
    logic                   rel_mode;
    logic                   cs_n_q;
    logic                   valid_q;
    logic [SADC_DATA_W-1:0] data_q;
    logic                   err_addr_q;
    logic                   err_to_q;

    logic                   sclk_run;
    logic                   rise_tick;
    logic                   fall_tick;
    logic                   timer_run;
    logic [CT_W-1:0]        conv_cnt;
    logic                   chan_bad;
    logic                   accept;
    logic                   sh_load;
    logic                   sh_shift;
    logic                   sh_in;
    logic [SADC_DATA_W-1:0] sh_q;

    // Request decode and datapath steering.
    always_comb begin
        chan_bad  = (req_chan[SADC_ADDR_W-1 -: 2] == 2'b11);
        accept    = (state == ST_IDLE) && req_valid && !chan_bad;
        sh_load   = accept;
        sh_shift  = ((state == ST_SEND) && fall_tick) ||
                    ((state == ST_READ) && rise_tick);
        sh_in     = (state == ST_READ) ? do_in : 1'b0;
        sclk_run  = (state == ST_SEND) || (state == ST_READ);
        timer_run = (state == ST_SETTLE) || (state == ST_WAIT);
    end

    sadc_sclk_gen #(
        .HALF (SCLK_HALF)
    ) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sclk_run),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sadc_conv_timer #(
        .DIV (CONV_DIV),
        .CW  (CT_W),
        .SAT (CONV_MAX + CONV_MARGIN)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .count (conv_cnt)
    );

    sadc_shifter #(
        .W (SADC_DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ({req_chan, {PAD_W{1'b0}}}),
        .shift_en (sh_shift),
        .shift_in (sh_in),
        .q        (sh_q)
    );

    // Transaction sequencer: handshake, frames, conversion wait, strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            edge_cnt   <= '0;
            settle_cnt <= '0;
            rel_mode   <= 1'b0;
            cs_n_q     <= 1'b1;
            valid_q    <= 1'b0;
            data_q     <= '0;
            err_addr_q <= 1'b0;
            err_to_q   <= 1'b0;
        end else begin
            valid_q    <= 1'b0;
            err_addr_q <= 1'b0;
            err_to_q   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && chan_bad) begin
                        err_addr_q <= 1'b1;
                    end else if (accept) begin
                        state    <= ST_SEND;
                        cs_n_q   <= 1'b0;
                        rel_mode <= req_release;
                        edge_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (fall_tick) begin
                        if (edge_cnt == FC_LAST) begin
                            edge_cnt   <= '0;
                            settle_cnt <= '0;
                            state      <= ST_SETTLE;
                            if (rel_mode) begin
                                cs_n_q <= 1'b1;
                            end
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SC_LAST) begin
                        state <= ST_WAIT;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (rel_mode) begin
                        if (conv_cnt >= CONV_DONE) begin
                            cs_n_q <= 1'b0;
                            state  <= ST_READ;
                        end
                    end else if (do_in) begin
                        state <= ST_READ;
                    end else if (conv_cnt >= CONV_LIMIT) begin
                        err_to_q <= 1'b1;
                        cs_n_q   <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (fall_tick) begin
                        if (edge_cnt == FC_LAST) begin
                            edge_cnt <= '0;
                            cs_n_q   <= 1'b1;
                            valid_q  <= 1'b1;
                            data_q   <= sh_q;
                            state    <= ST_IDLE;
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    cs_n_q <= 1'b1;
                end
            endcase
        end
    end

    // Output assignments.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        busy        = (state != ST_IDLE);
        res_valid   = valid_q;
        res_data    = data_q;
        err_addr    = err_addr_q;
        err_timeout = err_to_q;
        cs_n        = cs_n_q;
        di          = (state == ST_SEND) && sh_q[SADC_DATA_W-1];
    end

endmodule

// File: rtl/sadc_host_ctrl_chk.sv
// Property checker for sadc_host_ctrl, attached through bind. It watches
// the port-level protocol only.
module sadc_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_chan,
    input logic       req_ready,
    input logic       busy,
    input logic       res_valid,
    input logic       err_addr,
    input logic       err_timeout,
    input logic       cs_n,
    input logic       sclk,
    input logic       di
);

    // DI is held steady while SCLK is high.
    assert_di_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(di));

    // Test-mode addresses are refused with no transaction started.
    assert_reject_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_chan[3:2] == 2'b11)) |=> (err_addr && !busy && cs_n));

    // Legal addresses start a transaction with chip select low.
    assert_accept_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_chan[3:2] != 2'b11)) |=> (busy && !cs_n));

    // Busy ends only together with a result or a timeout.
    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (res_valid || err_timeout));

    // SCLK is idle whenever chip select is released.
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // The result strobe lasts one cycle.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // A timeout leaves the link released and the controller idle.
    assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (cs_n && !busy && !res_valid));

endmodule

bind sadc_host_ctrl sadc_host_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_ready   (req_ready),
    .busy        (busy),
    .res_valid   (res_valid),
    .err_addr    (err_addr),
    .err_timeout (err_timeout),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .di          (di)
);

// File: tb/tb_sadc_host_ctrl.sv
`timescale 1ns/1ps
// Directed bench for sadc_host_ctrl, with a behavioural converter model.
module tb_sadc_host_ctrl;

    localparam int HALF = 2, SETTLE = 20, CDIV = 4, CMAX = 64, CMARG = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_chan = 4'd0;
    logic       req_release = 1'b0;
    logic       req_ready, busy, res_valid, err_addr, err_timeout;
    logic       cs_n, sclk, di, do_line;
    logic [7:0] res_data;

    always #4 clk = ~clk;

    sadc_host_ctrl #(
        .SCLK_HALF (HALF), .SETTLE_CYC (SETTLE), .CONV_DIV (CDIV),
        .CONV_MAX (CMAX), .CONV_MARGIN (CMARG)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_chan (req_chan),
        .req_release (req_release), .req_ready (req_ready), .busy (busy),
        .res_valid (res_valid), .res_data (res_data), .err_addr (err_addr),
        .err_timeout (err_timeout), .cs_n (cs_n), .sclk (sclk), .di (di),
        .do_in (do_line)
    );

    int cyc = 0;
    int n_checks = 0;
    int n_errs = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lim);
        n_checks++;
        if (act < lim) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    // Converter model: phase 0 address, 1 converting, 2 result ready.
    logic [7:0] res_tab [16];
    logic       m_stuck = 1'b0;
    int         conv_len = 100;
    logic       m_sclk_q = 1'b0, m_cs_q = 1'b1;
    int         m_phase = 0, m_bits = 0, m_busy = 0, m_idx = 7;
    logic [3:0] m_addr = 4'd0, m_last_addr = 4'd0;
    logic [7:0] m_res = 8'd0;

    always @(posedge clk) begin
        m_sclk_q <= sclk;
        m_cs_q   <= cs_n;
        if (m_phase == 2 && cs_n && !m_cs_q) begin
            m_phase <= 0;
            m_bits  <= 0;
        end else begin
            case (m_phase)
                0: if (!m_cs_q) begin
                    if (!m_sclk_q && sclk && m_bits < 4) m_addr <= {m_addr[2:0], di};
                    if (m_sclk_q && !sclk) begin
                        if (m_bits == 7) begin
                            m_phase     <= 1;
                            m_busy      <= conv_len;
                            m_last_addr <= m_addr;
                            m_res       <= res_tab[m_addr];
                            m_bits      <= 0;
                        end else begin
                            m_bits <= m_bits + 1;
                        end
                    end
                end
                1: if (m_busy <= 1) begin
                    m_phase <= 2;
                    m_idx   <= 7;
                end else begin
                    m_busy <= m_busy - 1;
                end
                default: if (!m_cs_q && m_sclk_q && !sclk && m_idx > 0) m_idx <= m_idx - 1;
            endcase
        end
    end

    assign do_line = (cs_n || m_stuck || m_phase != 2) ? 1'b0 : m_res[m_idx];

    // Link monitor: edge counts and timing marks for the current transaction.
    logic       mon_clr = 1'b0;
    logic       mon_sclk_q = 1'b0, mon_cs_q = 1'b1;
    int         n_rise = 0, n_fall = 0, t_f8 = 0, t_r9 = 0, t_csl = 0;
    logic [7:0] di_cap = 8'd0;

    always @(posedge clk) begin
        mon_sclk_q <= sclk;
        mon_cs_q   <= cs_n;
        if (mon_clr) begin
            n_rise <= 0; n_fall <= 0; t_f8 <= 0; t_r9 <= 0; t_csl <= 0; di_cap <= 8'd0;
        end else begin
            if (!mon_sclk_q && sclk) begin
                n_rise <= n_rise + 1;
                if (n_rise < 8) di_cap <= {di_cap[6:0], di};
                if (n_fall == 8 && t_r9 == 0) t_r9 <= cyc;
            end
            if (mon_sclk_q && !sclk) begin
                n_fall <= n_fall + 1;
                if (n_fall == 7) t_f8 <= cyc;
            end
            if (n_fall == 8 && mon_cs_q && !cs_n && t_csl == 0) t_csl <= cyc;
        end
    end

    // One full transaction with result checks.
    task automatic xfer(input logic [3:0] ch, input logic rel, input logic [7:0] exp, input string tag);
        bit got = 0;
        int waited = 0;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        req_valid = 1'b1; req_chan = ch; req_release = rel;
        @(negedge clk); req_valid = 1'b0;
        check_eq({tag, " R3 busy after accept"}, int'(busy), 1);
        while (!got && waited < 4000) begin
            @(negedge clk); waited++;
            if (res_valid) got = 1;
        end
        check_eq({tag, " R8 result"}, int'(res_data), int'(exp));
        check_eq({tag, " R3 busy low at valid"}, int'(busy), 0);
        check_eq({tag, " R10 sclk rises"}, n_rise, 16);
        check_eq({tag, " R1 di frame"}, int'(di_cap), int'({ch, 4'b0000}));
        check_eq({tag, " R1 address seen by converter"}, int'(m_last_addr), int'(ch));
        check_eq({tag, " R10 cs_n high after read"}, int'(cs_n), 1);
        @(negedge clk);
        check_eq({tag, " R8 valid one cycle"}, int'(res_valid), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_eq("R4 sclk in reset", int'(sclk), 0);
        check_eq("R10 cs_n in reset", int'(cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R3 ready after reset", int'(req_ready), 1);
        check_eq("R3 busy after reset", int'(busy), 0);
        check_eq("R8 valid after reset", int'(res_valid), 0);
        check_eq("R1 di after reset", int'(di), 0);
    endtask

    task automatic t_reject;
        for (int k = 12; k < 16; k++) begin
            @(negedge clk); req_valid = 1'b1; req_chan = 4'(k); req_release = 1'b0;
            @(negedge clk); req_valid = 1'b0;
            check_eq("R2 err_addr pulse", int'(err_addr), 1);
            check_eq("R2 busy stays low", int'(busy), 0);
            check_eq("R2 cs_n stays high", int'(cs_n), 1);
            check_eq("R2 sclk stays low", int'(sclk), 0);
            @(negedge clk);
            check_eq("R2 err_addr one cycle", int'(err_addr), 0);
        end
    endtask

    task automatic t_watch;
        conv_len = 100;
        res_tab[3] = 8'hA5; res_tab[11] = 8'hC3; res_tab[0] = 8'h81;
        xfer(4'd3, 1'b0, 8'hA5, "watch ch3");
        check_eq("R6 cs_n low throughout", t_csl, 0);
        xfer(4'd11, 1'b0, 8'hC3, "watch ch11 R2 legal");
        xfer(4'd0, 1'b0, 8'h81, "watch ch0");
    endtask

    task automatic t_settle;
        conv_len = 5;
        res_tab[7] = 8'hFF;
        xfer(4'd7, 1'b0, 8'hFF, "settle ch7");
        check_ge("R5 sclk low after frame", t_r9 - t_f8, SETTLE);
        conv_len = 100;
    endtask

    task automatic t_release;
        conv_len = 100;
        res_tab[5] = 8'h3C; res_tab[9] = 8'h5A;
        xfer(4'd5, 1'b1, 8'h3C, "release ch5");
        check_ge("R7 cs_n high for full conversion", t_csl - t_f8, CMAX * CDIV);
        xfer(4'd9, 1'b1, 8'h5A, "release ch9");
        check_ge("R7 cs_n high for full conversion ch9", t_csl - t_f8, CMAX * CDIV);
    endtask

    task automatic t_timeout;
        bit got_to = 0, got_v = 0;
        int waited = 0;
        m_stuck = 1'b1;
        res_tab[4] = 8'h99;
        @(negedge clk); req_valid = 1'b1; req_chan = 4'd4; req_release = 1'b0;
        @(negedge clk); req_valid = 1'b0;
        while (!got_to && waited < 2000) begin
            @(negedge clk); waited++;
            if (err_timeout) got_to = 1;
            if (res_valid) got_v = 1;
        end
        check_eq("R9 timeout raised", int'(got_to), 1);
        check_eq("R9 no result", int'(got_v), 0);
        check_ge("R9 timeout not early", waited, (CMAX + CMARG) * CDIV);
        check_eq("R9 cs_n released", int'(cs_n), 1);
        check_eq("R9 idle after timeout", int'(busy), 0);
        @(negedge clk);
        check_eq("R9 timeout one cycle", int'(err_timeout), 0);
        m_stuck = 1'b0;
    endtask

    task automatic t_back_to_back;
        int waited = 0;
        conv_len = 100;
        res_tab[2] = 8'h96;
        @(negedge clk); req_valid = 1'b1; req_chan = 4'd2; req_release = 1'b0;
        while (m_phase != 1 && waited < 4000) begin @(negedge clk); waited++; end
        res_tab[2] = 8'hE1;
        while (!res_valid && waited < 4000) begin @(negedge clk); waited++; end
        check_eq("R11 first result", int'(res_data), 8'h96);
        check_eq("R11 ready in valid cycle", int'(req_ready), 1);
        @(negedge clk); req_valid = 1'b0;
        check_eq("R11 second request taken", int'(busy), 1);
        check_eq("R11 cs_n low again", int'(cs_n), 0);
        waited = 0;
        while (!res_valid && waited < 4000) begin @(negedge clk); waited++; end
        check_eq("R10 fresh conversion after read", int'(res_data), 8'hE1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (cyc < 150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) res_tab[k] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_reject();
        t_watch();
        t_settle();
        t_release();
        t_timeout();
        t_back_to_back();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule